// File: doc/BRIEF.md
# Guarded Data-EEPROM Access Controller

This block sits between a processor's byte-wide register bus and a small on-chip data EEPROM, which is modelled here as an internal byte array. Software reaches three registers: an address register, a data register and a control register. A read command copies the addressed byte into the data register in a single access. A write commits the data register to the addressed location once a self-timed busy period has elapsed.

A write is guarded by a two-step sequence. First, software sets an arming bit. That bit drops by itself after a fixed window of cycles. A write command issued while the arming bit is still set starts the write. A write command issued at any other time does nothing. Each accepted access raises a stall request toward the processor for a fixed number of cycles. A level interrupt reports that the array is ready to accept the next write.

The bus uses a 2-bit register select. Code 0 selects the address register, code 1 the data register and code 2 the control register. Code 3 selects nothing. The write time is a parameter counted in clock cycles.

Top module: `eeac_ctrl`

## Requirements
- R1: After reset, all three registers read as 0x00, `cpu_stall` is 0, `irq_ready` is 0 and every array byte is 0x00.
- R2: The address register keeps 6 bits, so writing 0xFF to select code 0 reads back as 0x3F. The data register (code 1) keeps all 8 bits.
- R3: A control write with bit 2 (arm) set and bit 1 (write command) clear sets the arm status. The arm status reads at control bit 2 for ARM_WINDOW (4) cycles and then clears by itself. A control write with both bit 2 and bit 1 set does not arm.
- R4: A control write with bit 1 set starts a write only when the arm status is set in that same cycle. A write command issued in the fourth cycle after arming is accepted. One issued in the fifth cycle or later leaves the busy status clear and the array unchanged.
- R5: After a write starts, the busy status (control readback bit 1) stays set for WRITE_CYCLES cycles and then clears. The stored byte holds the new value from the cycle in which busy clears.
- R6: A control write with bit 0 set, issued while no write is busy, loads the data register from the byte at the current address before the next cycle. Control readback bit 0 always reads 0.
- R7: `cpu_stall` is high for exactly 4 cycles after an accepted read command and for exactly 2 cycles after an accepted write start.
- R8: `irq_ready` is high exactly when the interrupt-enable bit (control bit 3, read back at bit 3) is set and no write is busy.
- R9: While a write is busy, read and write commands are ignored: the data register and `cpu_stall` do not change, and no second write begins. Changes to the address or data register during the busy period do not alter the byte that is being written.
- R10: `rdata` shows the selected register only while `rd_stb` is high, and shows 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| wr_stb | input | 1 | Register write strobe |
| rd_stb | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| cpu_stall | output | 1 | Stall request to the processor |
| irq_ready | output | 1 | Level interrupt: write path ready |

## Verification
The bound checker watches several rules on every cycle. The arm status may only rise after a valid arming write, and it may never last longer than its window. Busy may only rise after an armed write command. A stall run may never exceed the read stall length. Neither the interrupt nor a new stall may appear while busy. Only the bench's scenarios can show the values that flow through: which byte lands at which address, the exact cycle in which a late write command stops being accepted, and whether data-register edits during the busy period leak into the stored byte.

// File: rtl/eeac_pkg.sv
package eeac_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int BIT_RD_GO  = 0;
    localparam int BIT_WR_GO  = 1;
    localparam int BIT_ARM    = 2;
    localparam int BIT_IRQ_EN = 3;

    typedef struct packed {
        logic irq_en;
        logic arm;
        logic wr_go;
        logic rd_go;
    } ctrl_cmd_t;

    typedef struct packed {
        logic irq_en;
        logic armed;
        logic busy;
    } ctrl_stat_t;

    function automatic ctrl_cmd_t decode_cmd(input logic [7:0] b);
        ctrl_cmd_t c;
        c.rd_go  = b[BIT_RD_GO];
        c.wr_go  = b[BIT_WR_GO];
        c.arm    = b[BIT_ARM];
        c.irq_en = b[BIT_IRQ_EN];
        return c;
    endfunction

    function automatic logic [7:0] encode_stat(input ctrl_stat_t s);
        logic [7:0] b;
        b = 8'h00;
        b[BIT_WR_GO]  = s.busy;
        b[BIT_ARM]    = s.armed;
        b[BIT_IRQ_EN] = s.irq_en;
        return b;
    endfunction

endpackage

// File: rtl/eeac_downcnt.sv
module eeac_downcnt #(
    parameter int MAXV = 4,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          active,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);
    assign last   = (cnt == CW'(1));
endmodule

// File: rtl/eeac_store.sv
module eeac_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdat,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdat
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdat;
        end
    end

    assign rdat = cells[raddr];
endmodule

// File: rtl/eeac_ctrl.sv
module eeac_ctrl #(
    parameter int ADDR_W       = 6,
    parameter int ARM_WINDOW   = 4,
    parameter int WRITE_CYCLES = 40,
    parameter int READ_STALL   = 4,
    parameter int WRITE_STALL  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_sel,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       cpu_stall,
    output logic       irq_ready
);
    import eeac_pkg::*;

    localparam int STALL_MAX = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
    localparam int ARM_CW    = $clog2(ARM_WINDOW + 1);
    localparam int BUSY_CW   = $clog2(WRITE_CYCLES + 1);
    localparam int STALL_CW  = $clog2(STALL_MAX + 1);

    reg_sel_e   sel;
    ctrl_cmd_t  cmd;
    ctrl_stat_t stat;

    logic              ctrl_wr, arm_load, start_write, start_read;
    logic              arm_active, arm_last;
    logic              busy, busy_last;
    logic              stall_last;
    logic [STALL_CW-1:0] stall_val;

    logic [ADDR_W-1:0] addr_q, snap_addr;
    logic [7:0]        data_q, snap_data, mem_rdat;
    logic              irq_en_q;

    assign sel     = reg_sel_e'(reg_sel);
    assign cmd     = decode_cmd(wdata);
    assign ctrl_wr = wr_stb && (sel == SEL_CTRL);

    assign arm_load    = ctrl_wr && cmd.arm && !cmd.wr_go;
    assign start_write = ctrl_wr && cmd.wr_go && arm_active && !busy;
    assign start_read  = ctrl_wr && cmd.rd_go && !busy && !start_write;
    assign stall_val   = start_read ? STALL_CW'(READ_STALL) : STALL_CW'(WRITE_STALL);

    eeac_downcnt #(.MAXV(ARM_WINDOW)) arm_timer_i (
        .clk(clk), .rst(rst), .load(arm_load),
        .load_val(ARM_CW'(ARM_WINDOW)),
        .active(arm_active), .last(arm_last)
    );

    eeac_downcnt #(.MAXV(WRITE_CYCLES)) busy_timer_i (
        .clk(clk), .rst(rst), .load(start_write),
        .load_val(BUSY_CW'(WRITE_CYCLES)),
        .active(busy), .last(busy_last)
    );

    eeac_downcnt #(.MAXV(STALL_MAX)) stall_timer_i (
        .clk(clk), .rst(rst), .load(start_write || start_read),
        .load_val(stall_val),
        .active(cpu_stall), .last(stall_last)
    );

    eeac_store #(.ADDR_W(ADDR_W), .DATA_W(8)) store_i (
        .clk(clk), .rst(rst),
        .we(busy_last), .waddr(snap_addr), .wdat(snap_data),
        .raddr(addr_q), .rdat(mem_rdat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            data_q    <= '0;
            irq_en_q  <= 1'b0;
            snap_addr <= '0;
            snap_data <= '0;
        end else begin
            if (wr_stb && sel == SEL_ADDR) addr_q <= wdata[ADDR_W-1:0];
            if (start_read) begin
                data_q <= mem_rdat;
            end else if (wr_stb && sel == SEL_DATA) begin
                data_q <= wdata;
            end
            if (ctrl_wr) irq_en_q <= cmd.irq_en;
            if (start_write) begin
                snap_addr <= addr_q;
                snap_data <= data_q;
            end
        end
    end

    assign stat.busy   = busy;
    assign stat.armed  = arm_active;
    assign stat.irq_en = irq_en_q;

    always_comb begin
        rdata = 8'h00;
        if (rd_stb) begin
            unique case (sel)
                SEL_ADDR: rdata = 8'(addr_q);
                SEL_DATA: rdata = data_q;
                SEL_CTRL: rdata = encode_stat(stat);
                default:  rdata = 8'h00;
            endcase
        end
    end

    assign irq_ready = irq_en_q && !busy;

    logic unused_ok;
    assign unused_ok = arm_last ^ stall_last;
endmodule

// File: rtl/eeac_ctrl_chk.sv
module eeac_ctrl_chk #(
    parameter int ARM_WINDOW = 4,
    parameter int READ_STALL = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic [1:0] reg_sel,
    input logic [7:0] wdata,
    input logic       arm,
    input logic       busy,
    input logic       stall,
    input logic       irq_ready
);
    int arm_run, stall_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_run   <= 0;
            stall_run <= 0;
        end else begin
            arm_run   <= arm   ? arm_run + 1   : 0;
            stall_run <= stall ? stall_run + 1 : 0;
        end
    end

    // R3: arming only follows a control write with arm=1, write command=0
    assert_arm_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(arm) |-> $past(wr_stb && reg_sel == 2'd2 && wdata[2] && !wdata[1]));

    // R3: arm status never outlives its window
    assert_arm_window_R3: assert property (@(posedge clk) disable iff (rst)
        arm_run <= ARM_WINDOW);

    // R4: busy only begins after an armed write command
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm && wr_stb && reg_sel == 2'd2 && wdata[1]));

    // R7: no stall run is longer than the read stall
    assert_stall_len_R7: assert property (@(posedge clk) disable iff (rst)
        stall_run <= READ_STALL);

    // R8: interrupt is low during a write
    assert_irq_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq_ready);

    // R9: commands during a busy period start no new stall
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$rose(stall));
endmodule

bind eeac_ctrl eeac_ctrl_chk #(.ARM_WINDOW(ARM_WINDOW), .READ_STALL(READ_STALL)) chk_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .reg_sel(reg_sel), .wdata(wdata),
    .arm(arm_active), .busy(busy), .stall(cpu_stall), .irq_ready(irq_ready)
);

// File: tb/eeac_ctrl_tb.sv
module eeac_ctrl_tb_top;
    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] reg_sel;
    logic       wr_stb, rd_stb;
    logic [7:0] wdata, rdata;
    logic       cpu_stall, irq_ready;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    eeac_ctrl #(.WRITE_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .cpu_stall(cpu_stall), .irq_ready(irq_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        reg_sel = s; wdata = v; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s; rd_stb = 1'b1;
        #1 v = rdata;
        rd_stb = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(2'd2, v);
            if (!v[1]) break;
            idle(1);
        end
    endtask

    task automatic read_byte(input logic [5:0] a, output logic [7:0] v);
        wr(2'd0, {2'b00, a});
        wr(2'd2, 8'h01);
        rd(2'd1, v);
        idle(4);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 addr", v, 8'h00);
        rd(2'd1, v); chk("R1 data", v, 8'h00);
        rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 stall", {7'd0, cpu_stall}, 8'h00);
        chk("R1 irq", {7'd0, irq_ready}, 8'h00);
        read_byte(6'd33, v); chk("R1 array", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 addr width", v, 8'h3F);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 data", v, 8'hA5);
        reg_sel = 2'd1; rd_stb = 1'b0; #1;
        chk("R10 no strobe", rdata, 8'h00);
    endtask

    task automatic t_arm();
        logic [7:0] v;
        wr(2'd2, 8'h04);
        rd(2'd2, v); chk("R3 armed", v, 8'h04);
        idle(3); rd(2'd2, v); chk("R3 armed 4th", v, 8'h04);
        idle(1); rd(2'd2, v); chk("R3 expired", v, 8'h00);
        wr(2'd2, 8'h06);
        rd(2'd2, v); chk("R3 arm with wr bit", v, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        wr(2'd0, 8'h05); wr(2'd1, 8'h3C);
        wr(2'd2, 8'h04); idle(3);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R4 accepted 4th cycle", v, 8'h02);
        chk("R7 write stall c1", {7'd0, cpu_stall}, 8'h01);
        idle(1); chk("R7 write stall c2", {7'd0, cpu_stall}, 8'h01);
        idle(1); chk("R7 write stall end", {7'd0, cpu_stall}, 8'h00);
        idle(WR - 3); rd(2'd2, v); chk("R5 busy last", v, 8'h02);
        idle(1); rd(2'd2, v); chk("R5 busy clear", v, 8'h00);
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R6 read data", v, 8'h3C);
        rd(2'd2, v); chk("R6 rd bit reads 0", v, 8'h00);
        for (int k = 0; k < 4; k++) begin
            chk("R7 read stall", {7'd0, cpu_stall}, 8'h01);
            idle(1);
        end
        chk("R7 read stall end", {7'd0, cpu_stall}, 8'h00);
    endtask

    task automatic t_late();
        logic [7:0] v;
        wr(2'd0, 8'h06); wr(2'd1, 8'h77);
        wr(2'd2, 8'h04); idle(4);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R4 5th cycle no busy", v, 8'h00);
        idle(WR + 2);
        read_byte(6'd6, v); chk("R4 5th cycle array", v, 8'h00);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        wr(2'd0, 8'h07); wr(2'd1, 8'h11);
        wr(2'd2, 8'h04); wr(2'd2, 8'h02);
        idle(3);
        wr(2'd1, 8'h99); wr(2'd0, 8'h08);
        wr(2'd2, 8'h01);
        rd(2'd1, v); chk("R9 read ignored", v, 8'h99);
        chk("R9 no stall", {7'd0, cpu_stall}, 8'h00);
        wr(2'd2, 8'h04); wr(2'd2, 8'h02);
        wait_idle();
        idle(1); rd(2'd2, v); chk("R9 no second write", v, 8'h00);
        read_byte(6'd7, v); chk("R9 snapshot byte", v, 8'h11);
        read_byte(6'd8, v); chk("R9 other addr", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd2, 8'h08);
        chk("R8 irq idle", {7'd0, irq_ready}, 8'h01);
        rd(2'd2, v); chk("R8 irq en readback", v, 8'h08);
        wr(2'd0, 8'h09); wr(2'd1, 8'h42);
        wr(2'd2, 8'h0C); wr(2'd2, 8'h0A);
        chk("R8 irq busy", {7'd0, irq_ready}, 8'h00);
        wait_idle();
        chk("R8 irq back", {7'd0, irq_ready}, 8'h01);
        wr(2'd2, 8'h00);
        chk("R8 irq disabled", {7'd0, irq_ready}, 8'h00);
        read_byte(6'd9, v); chk("R5 stored", v, 8'h42);
    endtask

    initial begin
        #(8 * 150000);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_sel = 2'd3; wr_stb = 1'b0; rd_stb = 1'b0; wdata = 8'h00;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_regs();
        t_arm();
        t_write_read();
        t_late();
        t_busy_ignore();
        t_irq();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule